// File: doc/BRIEF.md
# Glitchless Redundant Clock Selector with Six-Way Fanout

The block chooses one of two free-running clocks, a primary and a backup, and passes the chosen one to six identical output copies. Moving from one source to the other never produces a shortened pulse. The outgoing source is first gated off while it is low. The incoming source is then gated on while it is low. For a short time between the two, the outputs sit low. Each source has its own enable, and each enable passes through a short chain of flops clocked on the falling edge of that source. A gate can therefore only open or close during the low phase of its own clock.

If the outgoing clock has died, its gate can never report that it has closed, so a normal handover stalls. A force control lets the handover finish anyway: it clears the deselected side's enable at once, without waiting for that side's clock. A separate output enable works without any clock. It switches all six outputs between the live clock and a parking level chosen by an input pin.

The control pins are plain levels and have no handshake. The clocks are raw clock nets and carry no data stream, so the block has no valid/ready interface.

Top module: `clk_failover_fanout`

## Requirements
- R1: While `rst_n_i` is low, the primary enable is set and the backup enable is cleared. With `sel_i`=1, the outputs follow `clk_pri_i` from the first clock after reset is released.
- R2: `sel_i`=1 selects `clk_pri_i` and `sel_i`=0 selects `clk_sec_i`. Once a handover has settled, every output equals the selected clock: high after its rising edge and low after its falling edge.
- R3: After `sel_i` changes, the outputs are low no later than the second falling edge of the previously selected clock. They stay low until the new source starts.
- R4: After the old source has stopped, the outputs start following the new clock on or before its third rising edge. No high or low pulse on an output is shorter than half the period of the faster input clock.
- R5: The primary enable and the backup enable are never on at the same time. The new side's enable is requested only after the old side's enable is off.
- R6: With `force_sw_i`=0, a selected-away clock that has stopped (stuck low or stuck high) blocks the handover. The outputs keep the stuck level of the old gated clock, and the new clock never appears.
- R7: With `force_sw_i`=1, the deselected side's enable is cleared without waiting for its clock. The outputs drop to low at once and then follow the new clock on or before its third rising edge.
- R8: `oe_i`=0 drives every output to the value of `park_lvl_i` (0 or 1) combinationally, with no clock needed. `oe_i`=1 returns the outputs to the gated clock.
- R9: All `N_OUT` outputs carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri_i | input | 1 | Primary clock source |
| clk_sec_i | input | 1 | Backup clock source |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Source select: 1 primary, 0 backup |
| force_sw_i | input | 1 | Completes a handover when the outgoing clock is dead |
| oe_i | input | 1 | Asynchronous output enable, 1 = live clock |
| park_lvl_i | input | 1 | Level driven on the outputs while disabled |
| clk_q_o | output | N_OUT (6) | Six identical gated clock copies |

## Verification
The release properties count rising edges of each clock only after reset. They assume that `sel_i` does not change on the same instant as a falling edge of either clock, and that `force_sw_i` is raised only while the outgoing clock is dead. The bench changes `sel_i` at offsets of 0.3 ns or 0.8 ns from any clock edge, sweeping the offset across sixteen handovers. It waits for each handover to settle before the next, and raises force only after it has stopped a clock. The runt-pulse monitor is switched off whenever `oe_i` or force is exercised, because those paths are allowed to cut a pulse short.

// File: rtl/clk_failover_pkg.sv
`timescale 1ns/100ps
package clk_failover_pkg;
  localparam int unsigned NUM_SIDES = 2;
  localparam int unsigned SIDE_SEC  = 0;
  localparam int unsigned SIDE_PRI  = 1;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  typedef logic [NUM_SIDES-1:0] side_vec_t;
endpackage

// File: rtl/clk_side_sync.sv
`timescale 1ns/100ps
// Falling-edge enable chain for one clock source. The last stage is the gate
// enable, so the gate only moves while this source is low.
module clk_side_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          INIT_ON = 1'b0
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic kill_i,
  input  logic req_i,
  output logic en_o
);
  logic [STAGES-1:0] stg_q;
  logic              arst;
  logic              load_v;

  assign arst   = ~por_n_i | kill_i;
  // reset loads the power-on value; a forced kill always loads zero
  assign load_v = por_n_i ? 1'b0 : INIT_ON;

  always_ff @(negedge clk_i or posedge arst) begin
    if (arst) stg_q <= {STAGES{load_v}};
    else      stg_q <= (stg_q << 1) | STAGES'(req_i);
  end

  assign en_o = stg_q[STAGES-1];
endmodule

// File: rtl/clk_handover_ctrl.sv
`timescale 1ns/100ps
// Break-before-make control: a side requests its gate only while it is the
// wanted side and the other side's gate is off.
module clk_handover_ctrl
  import clk_failover_pkg::*;
#(
  parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
  input  logic      clk_pri_i,
  input  logic      clk_sec_i,
  input  logic      rst_n_i,
  input  logic      sel_i,
  input  logic      force_sw_i,
  output side_vec_t en_o
);
  side_vec_t clk_v;
  side_vec_t want;
  side_vec_t req;
  side_vec_t kill;

  assign clk_v = {clk_pri_i, clk_sec_i};
  assign want  = {sel_i, ~sel_i};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam int unsigned OTHER = NUM_SIDES - 1 - s;
    localparam bit          START = (s == SIDE_PRI);
    assign req[s]  = want[s] & ~en_o[OTHER];
    // forced mode: drop the deselected side without its clock
    assign kill[s] = force_sw_i & ~want[s];
    clk_side_sync #(.STAGES(STAGES), .INIT_ON(START)) u_sync (
      .clk_i  (clk_v[s]),
      .por_n_i(rst_n_i),
      .kill_i (kill[s]),
      .req_i  (req[s]),
      .en_o   (en_o[s])
    );
  end
endmodule

// File: rtl/clk_out_stage.sv
`timescale 1ns/100ps
// One output copy: live gated clock or the parking level.
module clk_out_stage (
  input  logic live_i,
  input  logic oe_i,
  input  logic park_i,
  output logic q_o
);
  always_comb begin
    if (oe_i) q_o = live_i;
    else      q_o = park_i;
  end
endmodule

// File: rtl/clk_failover_fanout.sv
`timescale 1ns/100ps
module clk_failover_fanout
  import clk_failover_pkg::*;
#(
  parameter int unsigned N_OUT       = 6,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             clk_pri_i,
  input  logic             clk_sec_i,
  input  logic             rst_n_i,
  input  logic             sel_i,
  input  logic             force_sw_i,
  input  logic             oe_i,
  input  logic             park_lvl_i,
  output logic [N_OUT-1:0] clk_q_o
);
  side_vec_t side_en;
  side_vec_t side_clk;
  logic      live_clk;

  clk_handover_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .clk_pri_i (clk_pri_i),
    .clk_sec_i (clk_sec_i),
    .rst_n_i   (rst_n_i),
    .sel_i     (sel_i),
    .force_sw_i(force_sw_i),
    .en_o      (side_en)
  );

  assign side_clk = {clk_pri_i, clk_sec_i};
  assign live_clk = |(side_clk & side_en);

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    clk_out_stage u_stage (
      .live_i(live_clk),
      .oe_i  (oe_i),
      .park_i(park_lvl_i),
      .q_o   (clk_q_o[i])
    );
  end
endmodule

// File: rtl/clk_failover_fanout_chk.sv
`timescale 1ns/100ps
module clk_failover_fanout_chk #(
  parameter int unsigned N_OUT  = 6,
  parameter int unsigned STAGES = 2
) (
  input logic             clk_pri_i,
  input logic             clk_sec_i,
  input logic             rst_n_i,
  input logic             sel_i,
  input logic [1:0]       en_i,
  input logic [N_OUT-1:0] q_i
);
  logic [7:0] pri_off_cnt;
  logic [7:0] sec_off_cnt;

  // rising edges of each clock seen since reset with that side deselected
  always_ff @(posedge clk_pri_i or negedge rst_n_i) begin
    if (!rst_n_i)                 pri_off_cnt <= '0;
    else if (sel_i)               pri_off_cnt <= '0;
    else if (pri_off_cnt != 8'hFF) pri_off_cnt <= pri_off_cnt + 8'd1;
  end

  always_ff @(posedge clk_sec_i or negedge rst_n_i) begin
    if (!rst_n_i)                 sec_off_cnt <= '0;
    else if (!sel_i)              sec_off_cnt <= '0;
    else if (sec_off_cnt != 8'hFF) sec_off_cnt <= sec_off_cnt + 8'd1;
  end

  p_en_mutex_pri_r5: assert property (@(posedge clk_pri_i) disable iff (!rst_n_i)
    !(en_i[1] && en_i[0]));
  p_en_mutex_sec_r5: assert property (@(posedge clk_sec_i) disable iff (!rst_n_i)
    !(en_i[1] && en_i[0]));
  p_pri_released_r3: assert property (@(posedge clk_pri_i) disable iff (!rst_n_i)
    (!sel_i && pri_off_cnt >= 8'(STAGES)) |-> !en_i[1]);
  p_sec_released_r3: assert property (@(posedge clk_sec_i) disable iff (!rst_n_i)
    (sel_i && sec_off_cnt >= 8'(STAGES)) |-> !en_i[0]);
  p_fanout_equal_r9: assert property (@(posedge clk_pri_i) disable iff (!rst_n_i)
    (q_i == '0) || (q_i == '1));
endmodule

bind clk_failover_fanout clk_failover_fanout_chk #(
  .N_OUT (N_OUT),
  .STAGES(SYNC_STAGES)
) u_chk (
  .clk_pri_i(clk_pri_i),
  .clk_sec_i(clk_sec_i),
  .rst_n_i  (rst_n_i),
  .sel_i    (sel_i),
  .en_i     (side_en),
  .q_i      (clk_q_o)
);

// File: tb/clk_failover_fanout_bench.sv
`timescale 1ns/100ps
module clk_failover_fanout_bench;
  localparam int N_OUT = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;          // 125 MHz, primary source
  logic sec_raw = 1'b0;
  always #6.5 sec_raw = ~sec_raw; // unrelated backup period

  logic pri_run = 1'b1, pri_dc = 1'b0, sec_run = 1'b1, sec_dc = 1'b0;
  logic clk_pri, clk_sec;
  assign clk_pri = pri_run ? clk : pri_dc;
  assign clk_sec = sec_run ? sec_raw : sec_dc;

  logic rst_n = 1'b0, sel = 1'b1, force_sw = 1'b0, oe = 1'b1, park_lvl = 1'b0;
  logic [N_OUT-1:0] q;

  clk_failover_fanout u_clk_failover_fanout (
    .clk_pri_i(clk_pri), .clk_sec_i(clk_sec), .rst_n_i(rst_n), .sel_i(sel),
    .force_sw_i(force_sw), .oe_i(oe), .park_lvl_i(park_lvl), .clk_q_o(q)
  );

  int errors = 0, checks = 0;
  bit done = 1'b0;

  task automatic check_q(input string req, input logic [N_OUT-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%b expected %b at %0t", req, q, exp, $time);
    end
  endtask

  task automatic check_le(input string req, input int act, input int lim);
    checks++;
    if (act > lim) begin
      errors++;
      $display("FAIL %s: got %0d expected at most %0d", req, act, lim);
    end
  endtask

  task automatic wait_pos(input bit pri);
    if (pri) @(posedge clk_pri); else @(posedge clk_sec);
  endtask

  task automatic wait_neg(input bit pri);
    if (pri) @(negedge clk_pri); else @(negedge clk_sec);
  endtask

  // pulse-width monitor on one output copy
  realtime t_last = 0.0, t_arm = 0.0;
  bit mon_en = 1'b0;
  int runts = 0;
  always @(q[0]) begin
    if (mon_en && t_last >= t_arm && ($realtime - t_last) < 3.9) runts++;
    t_last = $realtime;
  end

  // count rising edges of the new clock before the outputs go high
  task automatic count_start(input bit pri, output int cnt);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      wait_pos(pri);
      #1;
      if (q[0]) break;
      cnt++;
    end
  endtask

  task automatic follow(input bit pri, input string req);
    for (int k = 0; k < 2; k++) begin
      wait_neg(pri); #1; check_q(req, '0);
      wait_pos(pri); #1; check_q(req, '1);
    end
  endtask

  task automatic handover(input bit to_pri);
    int cnt;
    sel = to_pri;
    repeat (2) wait_neg(!to_pri);
    #1; check_q("R3 old gate off", '0);
    count_start(to_pri, cnt);
    check_le("R4 new start edges", cnt, 2);
    follow(to_pri, "R2 follows selected");
  endtask

  initial begin
    int cnt;
    #20.5 rst_n = 1'b1;
    wait_pos(1'b1); #1; check_q("R1 primary after reset", '1);
    wait_neg(1'b1); #1; check_q("R1 primary after reset", '0);
    follow(1'b1, "R1 R9 primary after reset");

    mon_en = 1'b1; t_arm = $realtime;
    for (int i = 0; i < 16; i++) begin
      #(1.3 + i);
      handover(!sel);
    end
    mon_en = 1'b0;
    check_le("R4 runt pulses", runts, 0);

    // parking, sel is back on primary
    wait_neg(1'b1); #1;
    park_lvl = 1'b1; oe = 1'b0;
    #0.5 check_q("R8 park high", '1);
    park_lvl = 1'b0;
    #0.5 check_q("R8 park low", '0);
    wait_pos(1'b1); #1; check_q("R8 clock ignored", '0);
    park_lvl = 1'b1;
    wait_neg(1'b1); #1; check_q("R8 park high held", '1);
    wait_pos(1'b1); #1; check_q("R8 park high held", '1);
    wait_neg(1'b1); #1; oe = 1'b1;
    #0.5 check_q("R8 reenabled low", '0);
    wait_pos(1'b1); #1; check_q("R8 reenabled live", '1);

    // primary dies low, then move to backup
    wait_neg(1'b1); #1; pri_run = 1'b0; pri_dc = 1'b0;
    sel = 1'b0;
    for (int k = 0; k < 6; k++) begin
      wait_pos(1'b0); #1; check_q("R6 R5 blocked by dead low clock", '0);
    end
    force_sw = 1'b1;
    count_start(1'b0, cnt);
    check_le("R7 forced start edges", cnt, 2);
    follow(1'b0, "R7 forced follows backup");
    force_sw = 1'b0;
    @(negedge clk); #0.5 pri_run = 1'b1;

    // backup dies high, then move to primary
    wait_pos(1'b0); #0.5 sec_dc = 1'b1; sec_run = 1'b0;
    sel = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait_pos(1'b1); #1; check_q("R6 blocked by dead high clock", '1);
    end
    force_sw = 1'b1;
    #0.5 check_q("R7 forced drop", '0);
    count_start(1'b1, cnt);
    check_le("R7 forced start edges", cnt, 2);
    follow(1'b1, "R7 forced follows primary");
    force_sw = 1'b0;
    @(negedge sec_raw); #0.5 sec_dc = 1'b0; sec_run = 1'b1;

    #3.3 handover(1'b0);
    #2.3 handover(1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule